// File: doc/BRIEF.md
# Video Control Register Command Decoder

This block accepts a stream of bytes, one per accepted handshake cycle, and turns four-byte register-write commands into updates of a bank of 8-bit video control registers. Each command is a fixed two-byte prefix, then a register index, then a data byte. The decoded register contents come out as ready-made multi-byte fields: twelve 16-bit display timing values, a pixel-clock divider, two 24-bit frame-buffer base pointers, a colour-depth select and an output mode. Downstream scan-out logic reads these fields directly.

Two register copies are kept: a shadow bank and an active bank. All outputs come from the active bank. A lock command routes later writes into the shadow bank only. An unlock command then moves the whole shadow bank into the active bank in one clock cycle, so scan-out never sees a half-written mode. A byte stream that breaks the prefix raises a one-cycle error pulse. The parser then skips bytes until it sees a new prefix start.

The parser is a five-state machine. PARSE_IDLE waits at a command boundary for 0xAF. PARSE_HUNT silently discards bytes after an error until 0xAF arrives. PARSE_OPCODE expects 0x20. PARSE_INDEX captures the register index. PARSE_VALUE applies the write and returns to PARSE_IDLE. The transitions are:

- IDLE→OPCODE when the byte is 0xAF.
- IDLE→HUNT when the byte is anything else; this raises the error pulse.
- HUNT→OPCODE when the byte is 0xAF.
- OPCODE→INDEX when the byte is 0x20.
- OPCODE→OPCODE when the byte is 0xAF; this raises the error pulse.
- OPCODE→HUNT when the byte is anything else; this raises the error pulse.
- INDEX→VALUE on any byte.
- VALUE→IDLE on any byte.

Top module: `vrd_top`

## Requirements
- R1: During reset `in_ready` is low and it goes high after reset. On leaving reset every field reads zero, `out_mode` reads 0x07 and `locked` is low.
- R2: A command is the bytes 0xAF, 0x20, index, value. When the bank is unlocked, the written value shows on the outputs in the cycle after the value byte is accepted.
- R3: Cycles with `in_valid` low between bytes do not change how a command is decoded.
- R4: Timing field k (k = 0..11) sits in `timing[16k+15:16k]`. Its high byte comes from register 1+2k and its low byte from register 2+2k.
- R5: `pix_clk` takes its low byte from register 0x1B and its high byte from register 0x1C, in units of 5 kHz.
- R6: `base16` is {reg 0x20, reg 0x21, reg 0x22} and `base8` is {reg 0x26, reg 0x27, reg 0x28}, most significant byte first.
- R7: `depth_24` is bit 0 of register 0x00, where 0 means 16 bpp and 1 means 24 bpp. `out_mode` is register 0x1F, where 0x00 means syncs on, 0x01 means blanked and 0x07 means powered down.
- R8: Writing 0x00 to index 0xFF sets `locked`. While locked, register writes change no output.
- R9: Writing 0xFF to index 0xFF clears `locked`. Every write staged while locked then appears on the outputs together in the next cycle.
- R10: A write to index 0xFF with any other value, and a write to an index from 0x29 to 0xFE, leave all outputs and `locked` unchanged.
- R11: A byte other than 0xAF at a command boundary raises `cmd_err` for one cycle. The bytes that follow, up to the next 0xAF, are dropped without further errors.
- R12: A second byte other than 0x20 raises `cmd_err` for one cycle. If that byte is 0xAF, it is taken as the start of a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block can accept a byte |
| cmd_err | output | 1 | One-cycle malformed-prefix pulse |
| locked | output | 1 | Writes are staged in the shadow bank |
| depth_24 | output | 1 | 24-bpp colour depth select |
| out_mode | output | 8 | Output sync/power mode |
| timing | output | 192 | Twelve 16-bit timing fields |
| pix_clk | output | 16 | Pixel clock in 5 kHz units |
| base16 | output | 24 | 16-bpp frame-buffer base |
| base8 | output | 24 | 8-bpp frame-buffer base |

## Verification
The bench targets these corner cases, and the wrong behaviour each one would expose:
- **Pixel-clock byte swap.** A design that treats the pixel clock like the other fields would show the two bytes reversed in `pix_clk`.
- **Staging while locked.** Leaking a staged write early would change an output while `locked` is high.
- **Commit on unlock.** A partial copy at unlock would leave some staged fields stale.
- **Repeated prefix.** When 0xAF arrives in the opcode slot, a parser that drops it instead of restarting would lose the following command.
- **Single error per bad run.** A parser that raises an error on every byte of a bad run would fire `cmd_err` repeatedly while hunting.
- **Ignored writes.** Writes to unmapped indices, and odd values sent to index 0xFF, must change nothing.

Randomised command streams with idle gaps check the field byte order against a bench model of both banks.

// File: rtl/vrd_pkg.sv
package vrd_pkg;

    localparam logic [7:0] CMD_PREFIX = 8'hAF;
    localparam logic [7:0] CMD_OPCODE = 8'h20;
    localparam logic [7:0] CTRL_INDEX = 8'hFF;
    localparam logic [7:0] CTRL_LOCK = 8'h00;
    localparam logic [7:0] CTRL_UNLOCK = 8'hFF;

    localparam int REG_DEPTH = 8'h00;
    localparam int REG_TIMING0 = 8'h01;
    localparam int REG_PCLK_LO = 8'h1B;
    localparam int REG_PCLK_HI = 8'h1C;
    localparam int REG_MODE = 8'h1F;
    localparam int REG_BASE16 = 8'h20;
    localparam int REG_BASE8 = 8'h26;

    localparam logic [7:0] MODE_POWER_DOWN = 8'h07;

    typedef enum logic [2:0] {
        PARSE_IDLE,
        PARSE_HUNT,
        PARSE_OPCODE,
        PARSE_INDEX,
        PARSE_VALUE
    } parse_state_t;

endpackage

// File: rtl/vrd_parser.sv
module vrd_parser
    import vrd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_fire,
    input  logic [7:0] byte_in,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_val,
    output logic       err
);

    parse_state_t state_q, state_d;
    logic         bad_byte;
    logic [7:0]   idx_q;
    logic         err_q;

    // next-state decision
    always_comb begin
        state_d  = state_q;
        bad_byte = 1'b0;
        if (byte_fire) begin
            unique case (state_q)
                PARSE_IDLE: begin
                    if (byte_in == CMD_PREFIX) begin
                        state_d = PARSE_OPCODE;
                    end else begin
                        state_d  = PARSE_HUNT;
                        bad_byte = 1'b1;
                    end
                end
                PARSE_HUNT: begin
                    if (byte_in == CMD_PREFIX) begin
                        state_d = PARSE_OPCODE;
                    end
                end
                PARSE_OPCODE: begin
                    if (byte_in == CMD_OPCODE) begin
                        state_d = PARSE_INDEX;
                    end else begin
                        bad_byte = 1'b1;
                        state_d  = (byte_in == CMD_PREFIX) ? PARSE_OPCODE : PARSE_HUNT;
                    end
                end
                PARSE_INDEX: state_d = PARSE_VALUE;
                PARSE_VALUE: state_d = PARSE_IDLE;
                default:     state_d = PARSE_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PARSE_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= 8'h00;
            err_q <= 1'b0;
        end else begin
            err_q <= bad_byte;
            if (byte_fire && state_q == PARSE_INDEX) begin
                idx_q <= byte_in;
            end
        end
    end

    assign wr_en  = byte_fire && (state_q == PARSE_VALUE);
    assign wr_idx = idx_q;
    assign wr_val = byte_in;
    assign err    = err_q;

endmodule

// File: rtl/vrd_bank.sv
module vrd_bank
    import vrd_pkg::*;
#(
    parameter int NUM_REGS = 41
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_idx,
    input  logic [7:0]            wr_val,
    output logic                  locked,
    output logic [NUM_REGS*8-1:0] active_flat
);

    logic [7:0] shadow_q [NUM_REGS];
    logic [7:0] active_q [NUM_REGS];
    logic       locked_q;
    logic       ctrl_hit;
    logic       do_lock;
    logic       do_commit;
    logic       data_hit;

    assign ctrl_hit  = wr_en && (wr_idx == CTRL_INDEX);
    assign do_lock   = ctrl_hit && (wr_val == CTRL_LOCK);
    assign do_commit = ctrl_hit && (wr_val == CTRL_UNLOCK);
    assign data_hit  = wr_en && (int'(wr_idx) < NUM_REGS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
        end else if (do_lock) begin
            locked_q <= 1'b1;
        end else if (do_commit) begin
            locked_q <= 1'b0;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_entry
            localparam logic [7:0] RST_VAL = (g == REG_MODE) ? MODE_POWER_DOWN : 8'h00;
            logic sel;
            assign sel = data_hit && (int'(wr_idx) == g);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    shadow_q[g] <= RST_VAL;
                end else if (sel) begin
                    shadow_q[g] <= wr_val;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    active_q[g] <= RST_VAL;
                end else if (do_commit) begin
                    active_q[g] <= shadow_q[g];
                end else if (sel && !locked_q) begin
                    active_q[g] <= wr_val;
                end
            end

            assign active_flat[8*g +: 8] = active_q[g];
        end
    endgenerate

    assign locked = locked_q;

endmodule

// File: rtl/vrd_fields.sv
module vrd_fields
    import vrd_pkg::*;
#(
    parameter int NUM_REGS      = 41,
    parameter int TIMING_FIELDS = 12
) (
    input  logic [NUM_REGS*8-1:0]       regs_flat,
    output logic                        depth_24,
    output logic [7:0]                  out_mode,
    output logic [TIMING_FIELDS*16-1:0] timing,
    output logic [15:0]                 pix_clk,
    output logic [23:0]                 base16,
    output logic [23:0]                 base8
);

    genvar k;
    generate
        for (k = 0; k < TIMING_FIELDS; k++) begin : g_timing
            localparam int HI = REG_TIMING0 + 2 * k;
            assign timing[16*k +: 16] = {regs_flat[8*HI +: 8], regs_flat[8*(HI+1) +: 8]};
        end
    endgenerate

    assign depth_24 = regs_flat[8*REG_DEPTH];
    assign out_mode = regs_flat[8*REG_MODE +: 8];
    assign pix_clk  = {regs_flat[8*REG_PCLK_HI +: 8], regs_flat[8*REG_PCLK_LO +: 8]};
    assign base16   = {regs_flat[8*REG_BASE16 +: 8], regs_flat[8*(REG_BASE16+1) +: 8],
                       regs_flat[8*(REG_BASE16+2) +: 8]};
    assign base8    = {regs_flat[8*REG_BASE8 +: 8], regs_flat[8*(REG_BASE8+1) +: 8],
                       regs_flat[8*(REG_BASE8+2) +: 8]};

endmodule

// File: rtl/vrd_top.sv
module vrd_top
    import vrd_pkg::*;
#(
    parameter int NUM_REGS      = 41,
    parameter int TIMING_FIELDS = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [7:0]                  in_data,
    output logic                        in_ready,
    output logic                        cmd_err,
    output logic                        locked,
    output logic                        depth_24,
    output logic [7:0]                  out_mode,
    output logic [TIMING_FIELDS*16-1:0] timing,
    output logic [15:0]                 pix_clk,
    output logic [23:0]                 base16,
    output logic [23:0]                 base8
);

    logic                  ready_q;
    logic                  fire;
    logic                  wr_en;
    logic [7:0]            wr_idx;
    logic [7:0]            wr_val;
    logic [NUM_REGS*8-1:0] regs_flat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else begin
            ready_q <= 1'b1;
        end
    end

    assign in_ready = ready_q;
    assign fire     = in_valid && ready_q;

    vrd_parser u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_fire (fire),
        .byte_in   (in_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_val    (wr_val),
        .err       (cmd_err)
    );

    vrd_bank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_val      (wr_val),
        .locked      (locked),
        .active_flat (regs_flat)
    );

    vrd_fields #(.NUM_REGS(NUM_REGS), .TIMING_FIELDS(TIMING_FIELDS)) u_fields (
        .regs_flat (regs_flat),
        .depth_24  (depth_24),
        .out_mode  (out_mode),
        .timing    (timing),
        .pix_clk   (pix_clk),
        .base16    (base16),
        .base8     (base8)
    );

endmodule

// File: rtl/vrd_top_chk.sv
module vrd_top_chk #(
    parameter int TW = 192
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [7:0]    in_data,
    input logic          in_ready,
    input logic          cmd_err,
    input logic          locked,
    input logic [7:0]    out_mode,
    input logic [TW-1:0] timing,
    input logic [15:0]   pix_clk,
    input logic [23:0]   base16,
    input logic [23:0]   base8
);

    // R1
    ready_in_reset_chk: assert property (@(posedge clk) !rst_n |-> !in_ready);

    // R11
    err_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(in_valid && in_ready));

    // R8
    lock_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(in_valid && in_ready && in_data == 8'h00));

    // R9
    unlock_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(in_valid && in_ready && in_data == 8'hFF));

    // R8
    frozen_while_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> ($stable(timing) && $stable(pix_clk) &&
                                       $stable(base16) && $stable(base8) && $stable(out_mode)));

endmodule

bind vrd_top vrd_top_chk #(.TW(TIMING_FIELDS*16)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .cmd_err  (cmd_err),
    .locked   (locked),
    .out_mode (out_mode),
    .timing   (timing),
    .pix_clk  (pix_clk),
    .base16   (base16),
    .base8    (base8)
);

// File: tb/vrd_top_test.sv
module vrd_top_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   in_data = 8'h00;
    logic         in_ready, cmd_err, locked, depth_24;
    logic [7:0]   out_mode;
    logic [191:0] timing;
    logic [15:0]  pix_clk;
    logic [23:0]  base16, base8;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] m_shadow [41];
    logic [7:0] m_active [41];
    bit         m_locked;

    always #2.5 clk = ~clk;

    vrd_top uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .cmd_err(cmd_err), .locked(locked), .depth_24(depth_24),
        .out_mode(out_mode), .timing(timing), .pix_clk(pix_clk),
        .base16(base16), .base8(base8)
    );

    task automatic chk(input string req, input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [191:0] exp_timing();
        logic [191:0] t;
        for (int k = 0; k < 12; k++) t[16*k +: 16] = {m_active[1+2*k], m_active[2+2*k]};
        return t;
    endfunction

    task automatic check_all(input string req);
        chk({req, " timing R4"}, timing, exp_timing());
        chk({req, " pix_clk R5"}, 192'(pix_clk), 192'({m_active[8'h1C], m_active[8'h1B]}));
        chk({req, " base16 R6"}, 192'(base16), 192'({m_active[8'h20], m_active[8'h21], m_active[8'h22]}));
        chk({req, " base8 R6"}, 192'(base8), 192'({m_active[8'h26], m_active[8'h27], m_active[8'h28]}));
        chk({req, " depth R7"}, 192'(depth_24), 192'(m_active[0][0]));
        chk({req, " mode R7"}, 192'(out_mode), 192'(m_active[8'h1F]));
        chk({req, " locked R8"}, 192'(locked), 192'(m_locked));
    endtask

    // one byte per call; returns at the negedge after acceptance
    task automatic send(input logic [7:0] b);
        in_valid = 1'b1;
        in_data  = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic model_write(input logic [7:0] idx, input logic [7:0] val);
        if (idx == 8'hFF) begin
            if (val == 8'h00) m_locked = 1'b1;
            else if (val == 8'hFF) begin
                m_locked = 1'b0;
                for (int i = 0; i < 41; i++) m_active[i] = m_shadow[i];
            end
        end else if (idx < 8'd41) begin
            m_shadow[idx] = val;
            if (!m_locked) m_active[idx] = val;
        end
    endtask

    task automatic write_cmd(input logic [7:0] idx, input logic [7:0] val, input int gaps);
        send(8'hAF); gap(gaps);
        send(8'h20); gap(gaps);
        send(idx);   gap(gaps);
        send(val);
        model_write(idx, val);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1234));
        for (int i = 0; i < 41; i++) begin
            m_shadow[i] = 8'h00;
            m_active[i] = 8'h00;
        end
        m_shadow[8'h1F] = 8'h07;
        m_active[8'h1F] = 8'h07;
        m_locked = 1'b0;

        gap(3);
        chk("R1 ready low in reset", 192'(in_ready), 192'd0);
        rst_n = 1'b1;
        gap(2);
        chk("R1 ready after reset", 192'(in_ready), 192'd1);
        chk("R1 no error after reset", 192'(cmd_err), 192'd0);
        check_all("R1 reset state");

        // R2 basic writes, R5 pixel clock byte order, R7 mode
        write_cmd(8'h1B, 8'h34, 0);
        write_cmd(8'h1C, 8'h12, 0);
        check_all("R2 R5 direct");
        chk("R5 pix_clk value", 192'(pix_clk), 192'h1234);
        write_cmd(8'h01, 8'hAB, 0);
        write_cmd(8'h02, 8'hCD, 0);
        chk("R4 field0 high-first", 192'(timing[15:0]), 192'hABCD);
        write_cmd(8'h1F, 8'h00, 0);
        chk("R7 syncs on", 192'(out_mode), 192'h00);
        // R3 gaps inside a command
        write_cmd(8'h20, 8'h11, 3);
        write_cmd(8'h22, 8'h33, 2);
        check_all("R3 R6 with gaps");

        // R8 lock and staging, R9 commit
        write_cmd(8'hFF, 8'h00, 0);
        write_cmd(8'h17, 8'h55, 0);
        write_cmd(8'h28, 8'h66, 1);
        write_cmd(8'h00, 8'h01, 0);
        check_all("R8 staged hidden");
        chk("R8 depth unchanged", 192'(depth_24), 192'd0);
        write_cmd(8'hFF, 8'hFF, 0);
        check_all("R9 commit");
        chk("R9 depth committed", 192'(depth_24), 192'd1);
        chk("R9 base8 committed", 192'(base8), 192'h000066);

        // R10 ignored writes
        write_cmd(8'hFF, 8'h5A, 0);
        write_cmd(8'h30, 8'h99, 0);
        write_cmd(8'hFE, 8'h77, 0);
        check_all("R10 ignored");

        // R11 bad first byte, silent hunt
        send(8'h12);
        chk("R11 error pulse", 192'(cmd_err), 192'd1);
        send(8'h34);
        chk("R11 silent hunt", 192'(cmd_err), 192'd0);
        write_cmd(8'h1B, 8'h55, 0);
        check_all("R11 resync");

        // R12 bad opcode, then repeated prefix restarts
        send(8'hAF);
        send(8'h99);
        chk("R12 bad opcode error", 192'(cmd_err), 192'd1);
        send(8'h11);
        chk("R12 hunting silent", 192'(cmd_err), 192'd0);
        send(8'hAF);
        send(8'hAF);
        chk("R12 prefix in opcode slot error", 192'(cmd_err), 192'd1);
        send(8'h20); send(8'h1C); send(8'h66);
        model_write(8'h1C, 8'h66);
        chk("R12 restarted command", 192'(pix_clk), 192'h6655);

        // random phase
        for (int n = 0; n < 400; n++) begin
            int sel;
            logic [7:0] idx, val;
            sel = int'($urandom_range(0, 19));
            val = 8'($urandom);
            if (sel == 0) begin idx = 8'hFF; val = 8'h00; end
            else if (sel == 1) begin idx = 8'hFF; val = 8'hFF; end
            else if (sel == 2) idx = 8'($urandom_range(8'h29, 8'hFF));
            else idx = 8'($urandom_range(0, 40));
            write_cmd(idx, val, int'($urandom_range(0, 1)));
            chk("R2 no error on valid stream", 192'(cmd_err), 192'd0);
            check_all("R2 random");
        end
        write_cmd(8'hFF, 8'hFF, 0);
        check_all("R9 final commit");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule